// File: doc/BRIEF.md
# Page-Program Write Buffer with In-Page Wrap

This block sits on the device side of a serial flash and collects the data phase of a page-program command. A front end that has already decoded the opcode and address presents a one-cycle header carrying the 24-bit target address and a lane selector. The selector picks either one data bit per beat or two bits per beat. The upper address bits pick a 256-byte page. The low address byte gives the first byte offset, and the offset then wraps inside the page. A burst longer than a page therefore overwrites its own earliest bytes, and the page ends up holding the last 256 bytes that were shifted in.

When chip select is released after at least one whole byte, the block starts a self-timed programming step. It passes the page number on `prog_page` and a per-byte written mask on `prog_mask`, and it holds `busy` for a programmable number of clock cycles. The data stream into the block uses valid/ready. A beat moves only in a cycle where `bit_valid` and `bit_ready` are both high. `bit_ready` is low for the whole busy window, so the source must hold its beat until ready returns. Headers that arrive while busy are dropped. Control pins (`sel_n`, `wel`, `prot`) are plain levels.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset `busy` and `prog_start` are 0, `prog_mask` is all zeros, `bit_ready` is 1, and every buffer byte reads 8'hFF on `rd_data`.
- R2: In single-lane mode (`hdr_dual`=0) each accepted beat carries one bit on `bit_data[0]`, most significant bit first. Eight beats form one byte, and the first byte is stored at offset `hdr_addr[7:0]`.
- R3: In dual-lane mode (`hdr_dual`=1) each accepted beat carries two bits, with `bit_data[1]` the more significant. Four beats form one byte.
- R4: After each stored byte the offset increases by one modulo 256, so the offset after 8'hFF is 8'h00. When more than 256 bytes are sent, each offset holds the last byte written to it.
- R5: `prog_mask[i]` is 1 exactly when offset i was written since the last accepted header. Offsets not written keep their earlier contents. `prog_mask` and `prog_page` do not change while `busy` is high.
- R6: A rising edge of `sel_n` after at least one whole byte makes `prog_start` high for exactly one cycle, in the cycle after the rise. At that point `prog_page` equals `hdr_addr[23:8]`.
- R7: Bits of an incomplete trailing byte are discarded. If `sel_n` rises before a whole byte has been received, the command is aborted: there is no `prog_start`, no busy period and no buffer change.
- R8: A header with `wel`=0 or `prot`=1 is ignored. Its bits store nothing, its mask is not cleared, and no program starts.
- R9: `busy` rises together with `prog_start` and stays high for exactly BUSY_CYCLES cycles.
- R10: While `busy` is high, `bit_ready` is 0, and headers and beats are not accepted.
- R11: A beat is taken only when `sel_n` is low, `bit_valid` and `bit_ready` are high, and an accepted header is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Chip select, active low; a rising edge ends the command |
| hdr_valid | input | 1 | One-cycle pulse: decoded program header present |
| hdr_dual | input | 1 | 1 = two bits per beat, 0 = one bit per beat |
| hdr_addr | input | 24 | Target address: [23:8] page, [7:0] first offset |
| wel | input | 1 | Write-enable latch state |
| prot | input | 1 | Target address is write-protected |
| bit_valid | input | 1 | Data beat valid |
| bit_ready | output | 1 | Block can take a beat |
| bit_data | input | 2 | Beat bits; single lane uses bit 0 |
| rd_addr | input | 8 | Buffer read offset |
| rd_data | output | 8 | Buffer byte at `rd_addr` |
| prog_start | output | 1 | One-cycle launch of the programming step |
| prog_page | output | 16 | Page number being programmed |
| prog_mask | output | 256 | Per-byte written mask |
| busy | output | 1 | Programming step in progress |

## Verification
The assertions check on every cycle that the launch pulse lasts one cycle and comes with busy, and that the page and mask stay frozen through the busy window. They also check that a stored byte sets its mask bit, that the busy counter stays in range, and that the dual-lane bit count stays even. Only the bench scenarios can show that the right byte values land at the right offsets. These scenarios cover in-page wrap, the last-256 rule for oversized bursts, the discarding of partial bytes, and aborts and rejected commands that leave the buffer untouched.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;
  typedef enum logic {LANE_SINGLE = 1'b0, LANE_DUAL = 1'b1} lane_e;
endpackage

// File: rtl/pp_bit_gather.sv
`timescale 1ns/1ps
module pp_bit_gather
  import pp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       take,
  input  lane_e      lane,
  input  logic [1:0] bits,
  output logic       byte_done,
  output logic [7:0] byte_val
);
  logic [6:0] sr;
  logic [2:0] cnt;

  always_comb begin
    if (lane == LANE_DUAL) begin
      byte_val  = {sr[5:0], bits};
      byte_done = take && (cnt == 3'd6);
    end else begin
      byte_val  = {sr, bits[0]};
      byte_done = take && (cnt == 3'd7);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (take) begin
      if (lane == LANE_DUAL) begin
        sr  <= {sr[4:0], bits};
        cnt <= cnt + 3'd2;
      end else begin
        sr  <= {sr[5:0], bits[0]};
        cnt <= cnt + 3'd1;
      end
    end
  end

  AST_DUAL_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lane == LANE_DUAL) |-> !cnt[0]); // R3
endmodule

// File: rtl/pp_page_store.sv
`timescale 1ns/1ps
module pp_page_store #(
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [OFF_W-1:0]      waddr,
  input  logic [7:0]            wdata,
  input  logic                  mask_clr,
  input  logic [OFF_W-1:0]      raddr,
  output logic [7:0]            rdata,
  output logic [PAGE_BYTES-1:0] mask
);
  logic [7:0] mem [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (mask_clr) begin
      mask <= '0;
    end else if (we) begin
      mask[waddr] <= 1'b1;
    end
  end

  assign rdata = mem[raddr];

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !mask_clr) |=> mask[$past(waddr)]); // R5
endmodule

// File: rtl/pp_busy_timer.sv
`timescale 1ns/1ps
module pp_busy_timer #(
  parameter int BUSY_CYCLES = 75000,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(BUSY_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BUSY_CYCLES - 1)); // R9
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cnt == '0)); // R9
endmodule

// File: rtl/page_prog_buffer.sv
`timescale 1ns/1ps
module page_prog_buffer
  import pp_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int PAGE_BYTES  = 256,
  parameter int BUSY_CYCLES = 75000,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_n,
  input  logic                  hdr_valid,
  input  logic                  hdr_dual,
  input  logic [ADDR_W-1:0]     hdr_addr,
  input  logic                  wel,
  input  logic                  prot,
  input  logic                  bit_valid,
  output logic                  bit_ready,
  input  logic [1:0]            bit_data,
  input  logic [OFF_W-1:0]      rd_addr,
  output logic [7:0]            rd_data,
  output logic                  prog_start,
  output logic [PAGE_W-1:0]     prog_page,
  output logic [PAGE_BYTES-1:0] prog_mask,
  output logic                  busy
);
  logic             armed, got_byte, sel_q;
  lane_e            lane;
  logic [OFF_W-1:0] off;
  logic             take, hdr_take, hdr_ok, sel_rise, launch;
  logic             byte_done;
  logic [7:0]       byte_val;

  assign bit_ready = !busy;
  assign take      = armed && !sel_n && bit_valid && bit_ready;
  assign hdr_take  = hdr_valid && !sel_n && !busy;
  assign hdr_ok    = hdr_take && wel && !prot;
  assign sel_rise  = sel_n && !sel_q;
  assign launch    = sel_rise && armed && got_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b1;
      armed      <= 1'b0;
      got_byte   <= 1'b0;
      lane       <= LANE_SINGLE;
      off        <= '0;
      prog_page  <= '0;
      prog_start <= 1'b0;
    end else begin
      sel_q      <= sel_n;
      prog_start <= launch;
      if (sel_rise) begin
        armed <= 1'b0;
      end else if (hdr_take) begin
        armed <= hdr_ok;
        if (hdr_ok) begin
          lane      <= lane_e'(hdr_dual);
          prog_page <= hdr_addr[ADDR_W-1:OFF_W];
          off       <= hdr_addr[OFF_W-1:0];
          got_byte  <= 1'b0;
        end
      end else if (byte_done) begin
        off      <= off + 1'b1;
        got_byte <= 1'b1;
      end
    end
  end

  pp_bit_gather u_gather (
    .clk(clk), .rst_n(rst_n), .clear(hdr_ok), .take(take), .lane(lane),
    .bits(bit_data), .byte_done(byte_done), .byte_val(byte_val)
  );

  pp_page_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(byte_done), .waddr(off), .wdata(byte_val),
    .mask_clr(hdr_ok), .raddr(rd_addr), .rdata(rd_data), .mask(prog_mask)
  );

  pp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(launch), .busy(busy)
  );

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start); // R6
  AST_START_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(sel_n)); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> busy); // R9
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(prog_mask) && $stable(prog_page))); // R5
endmodule

// File: tb/page_prog_buffer_bench.sv
`timescale 1ns/1ps
module page_prog_buffer_bench;
  localparam int BC = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_n = 1'b1;
  logic         hdr_valid = 1'b0;
  logic         hdr_dual = 1'b0;
  logic [23:0]  hdr_addr = '0;
  logic         wel = 1'b1;
  logic         prot = 1'b0;
  logic         bit_valid = 1'b0;
  logic         bit_ready;
  logic [1:0]   bit_data = '0;
  logic [7:0]   rd_addr = '0;
  logic [7:0]   rd_data;
  logic         prog_start;
  logic [15:0]  prog_page;
  logic [255:0] prog_mask;
  logic         busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0]   m_mem [256];
  logic [255:0] m_mask = '0;
  logic [7:0]   m_off;
  logic [15:0]  m_page;
  bit           m_dual, m_acc;

  always #10 clk = ~clk;

  page_prog_buffer #(.BUSY_CYCLES(BC)) u_page_prog_buffer (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .hdr_valid(hdr_valid),
    .hdr_dual(hdr_dual), .hdr_addr(hdr_addr), .wel(wel), .prot(prot),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .prog_start(prog_start),
    .prog_page(prog_page), .prog_mask(prog_mask), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_buffer(input string req);
    int bad = -1;
    for (int i = 0; i < 256; i++) begin
      rd_addr = 8'(i);
      #1;
      if (rd_data !== m_mem[i] && bad < 0) bad = i;
    end
    checks++;
    if (bad >= 0) begin
      failures++;
      rd_addr = 8'(bad);
      #1;
      $display("FAIL %s offset=%0h actual=%0h expected=%0h", req, bad, rd_data, m_mem[bad]);
    end
    checks++;
    if (prog_mask !== m_mask) begin
      failures++;
      $display("FAIL %s mask actual=%0h expected=%0h", req, prog_mask, m_mask);
    end
  endtask

  task automatic open_cmd(input logic [23:0] a, input bit dual, input bit w, input bit p);
    @(negedge clk);
    sel_n = 1'b0;
    @(negedge clk);
    hdr_valid = 1'b1; hdr_addr = a; hdr_dual = dual; wel = w; prot = p;
    m_acc = !busy && w && !p;
    if (m_acc) begin
      m_off = a[7:0]; m_page = a[23:8]; m_dual = dual; m_mask = '0;
    end
    @(negedge clk);
    hdr_valid = 1'b0; wel = 1'b1; prot = 1'b0;
  endtask

  task automatic push_bits(input logic [7:0] b, input int nbits);
    int k = 0;
    while (k < nbits) begin
      bit_valid = 1'b1;
      if (m_dual) bit_data = {b[7-k], b[6-k]};
      else        bit_data = {1'b0, b[7-k]};
      @(negedge clk);
      k += m_dual ? 2 : 1;
    end
    bit_valid = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    push_bits(b, 8);
    if (m_acc) begin
      m_mem[m_off] = b; m_mask[m_off] = 1'b1; m_off = m_off + 8'd1;
    end
  endtask

  task automatic close_cmd(input bit exp_start, input string req);
    int n = 0;
    sel_n = 1'b1;
    @(negedge clk);
    chk(prog_start === exp_start, req, prog_start, exp_start);
    if (exp_start) begin
      chk(prog_page === m_page, "R6 page", prog_page, m_page);
      while (busy === 1'b1 && n < 1000) begin
        n++;
        @(negedge clk);
        if (n == 1) chk(prog_start === 1'b0, "R6 single-cycle", prog_start, 0);
      end
      chk(n == BC, "R9 busy length", n, BC);
    end else begin
      chk(busy === 1'b0, req, busy, 0);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
    m_mask = '0; m_dual = 0; m_acc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 0 && prog_start === 0, "R1 idle outputs", {busy, prog_start}, 0);
    chk(bit_ready === 1'b1, "R1 ready", bit_ready, 1);
    cmp_buffer("R1 reset contents");
  endtask

  task automatic t_single;
    open_cmd(24'h012340, 0, 1, 0);
    push_byte(8'hA5); push_byte(8'h3C);
    close_cmd(1, "R2 single start");
    cmp_buffer("R2 single bytes");
  endtask

  task automatic t_dual;
    open_cmd(24'h0ABC80, 1, 1, 0);
    push_byte(8'hD2); push_byte(8'h69); push_byte(8'h17);
    close_cmd(1, "R3 dual start");
    cmp_buffer("R3 dual bytes");
  endtask

  task automatic t_wrap;
    open_cmd(24'h1234FE, 0, 1, 0);
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
    close_cmd(1, "R4 wrap start");
    cmp_buffer("R4 wrap offsets");
  endtask

  task automatic t_keep;
    open_cmd(24'h000041, 1, 1, 0);
    push_byte(8'hE7);
    close_cmd(1, "R5 keep start");
    cmp_buffer("R5 untouched bytes kept");
  endtask

  task automatic t_partial;
    open_cmd(24'h000060, 0, 1, 0);
    push_byte(8'h9E);
    push_bits(8'hFF, 3);
    close_cmd(1, "R7 partial start");
    cmp_buffer("R7 trailing bits dropped");
  endtask

  task automatic t_abort;
    open_cmd(24'h000070, 0, 1, 0);
    push_bits(8'h00, 5);
    close_cmd(0, "R7 abort no start");
    cmp_buffer("R7 abort buffer");
  endtask

  task automatic t_reject;
    open_cmd(24'h000090, 0, 0, 0);
    push_byte(8'h44);
    close_cmd(0, "R8 no wel");
    cmp_buffer("R8 no wel buffer");
    open_cmd(24'h0000A0, 1, 1, 1);
    push_byte(8'h55);
    close_cmd(0, "R8 protected");
    cmp_buffer("R8 protected buffer");
    @(negedge clk);
    bit_valid = 1'b1; bit_data = 2'b11;
    repeat (8) @(negedge clk);
    bit_valid = 1'b0;
    cmp_buffer("R11 beats without header");
  endtask

  task automatic t_busy;
    int n = 0;
    open_cmd(24'h000020, 0, 1, 0);
    push_byte(8'h6B);
    sel_n = 1'b1;
    @(negedge clk);
    chk(prog_start === 1'b1, "R6 start", prog_start, 1);
    sel_n = 1'b0;
    @(negedge clk);
    chk(bit_ready === 1'b0, "R10 ready low", bit_ready, 0);
    hdr_valid = 1'b1; hdr_addr = 24'h0000C0; hdr_dual = 0;
    @(negedge clk);
    hdr_valid = 1'b0;
    bit_valid = 1'b1; bit_data = 2'b01;
    repeat (8) @(negedge clk);
    bit_valid = 1'b0;
    sel_n = 1'b1;
    @(negedge clk);
    chk(prog_start === 1'b0, "R10 no restart", prog_start, 0);
    while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    chk(prog_start === 1'b0, "R10 header dropped", prog_start, 0);
    cmp_buffer("R10 buffer unchanged");
  endtask

  task automatic t_long;
    open_cmd(24'h055510, 1, 1, 0);
    for (int i = 0; i < 258; i++) push_byte(8'(i * 7 + 3));
    close_cmd(1, "R4 long start");
    cmp_buffer("R4 last 256 kept");
  endtask

  initial begin
    t_reset;
    t_single;
    t_dual;
    t_wrap;
    t_keep;
    t_partial;
    t_abort;
    t_reject;
    t_busy;
    t_long;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule